// File: doc/BRIEF.md
# Sectored Wait-State External Memory Bus Controller

This block connects an 8-bit processor core to parallel memory outside the chip. Each transfer is carried over a multiplexed bus. The low address byte and the data byte share one set of lines. The high address byte has its own lines, and an address latch strobe lets external logic capture the low byte. Active-low read and write strobes then mark the data phase. The core raises a request with an address, a direction and write data while the block is idle. The block answers with a one-cycle ready pulse, and on a read it returns the byte it sampled from the bus.

The external address space can be cut into a lower and an upper sector at a programmable boundary. Each sector has its own wait-state code. The slowest code also leaves one idle cycle before the next address goes out, which gives slow devices time to release the bus. Two configuration registers hold the following settings:
- the enable bit, which gives the bus pins to this block;
- the sector split;
- the wait-state code of each sector;
- a bus keeper, which holds the last driven byte on the shared lines while they float;
- a mask that frees high address pins, starting from the top bit.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset both configuration registers read 0. In that state ale is 0, rd_n and wr_n are 1, ad_oe is 0, ready is 0, bus_own is 0 and a_oe is 0.
- R2: Register 0 (cfg_sel=0) reads back all 8 bits as written. Its fields are: bit 0 enable, bits 3:1 sector limit, bits 5:4 lower-sector wait code, bits 7:6 upper-sector wait code. Register 1 (cfg_sel=1) holds bit 0 keeper enable and bits 3:1 high-mask code. Its bits 7:4 always read 0.
- R3: bus_own equals the enable bit. While enable is 0, a request is ignored: no ale pulse and no ready pulse appear, and a_oe stays 0.
- R4: An accepted request gives exactly one cycle with ale=1. In that cycle ad_oe=1 and ad_o carries addr[7:0]. The strobe phase starts in the cycle right after it.
- R5: The strobe lasts 1, 2, 3 or 3 cycles for wait codes 0, 1, 2 and 3.
- R6: With the same wait code on back-to-back requests (req held high), ale rises every 3, 4 or 5 cycles for codes 0, 1 and 2. Code 3 gives 6 cycles, because of one added idle cycle.
- R7: For sector-limit codes 2 to 7, the upper sector starts at code×0x2000. An address below that start uses the lower-sector code, and an address at or above it uses the upper-sector code.
- R8: For sector-limit codes 0 and 1, every access uses the upper-sector wait code.
- R9: On a write, wr_n is 0 and rd_n is 1 in every strobe cycle. In those cycles ad_oe is 1 and ad_o equals wdata.
- R10: On a read, rd_n is 0 and ad_oe is 0 in every strobe cycle. rdata takes the ad_in value present in the last strobe cycle. ready is high for exactly one cycle, the cycle after the last strobe.
- R11: For high-mask code m, a_oe has its n lowest bits set, where n is 8−m for m from 0 to 6 and 0 for m=7. a_o equals the latched addr[15:8] masked by a_oe, so masked pins read 0.
- R12: ad_keep equals the keeper bit while ad_oe is 0, even when the enable bit is 0. While ad_oe is 0, ad_o holds the last value driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Configuration register select (0 or 1) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register read data |
| req | input | 1 | Core access request, taken only when idle |
| we | input | 1 | Access direction: 1 write, 0 read |
| addr | input | 16 | Core access address |
| wdata | input | 8 | Core write data |
| rdata | output | 8 | Read data returned to the core |
| ready | output | 1 | One-cycle completion pulse |
| bus_own | output | 1 | Block owns the shared bus, latch and strobe pins |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Shared address/data lines, output value |
| ad_oe | output | 1 | Shared lines driven by the block |
| ad_in | input | 8 | Shared lines, input value |
| ad_keep | output | 1 | Bus keeper active on the shared lines |
| a_o | output | 8 | High address byte output |
| a_oe | output | 8 | Per-pin ownership of the high address byte |

## Verification
The hardest condition to reach is proof that read data is captured in the last strobe cycle and not an earlier one. The bench changes ad_in in every strobe cycle to a value that encodes the cycle index. The returned byte therefore shows which cycle was sampled. The sector boundary is the next hardest. The bench sets the two sectors to different wait codes and runs accesses one byte below and exactly at each start point. It then tells the sectors apart by the strobe length it counts. The idle cycle added by the slowest code shows only between back-to-back accesses, so the bench holds the request high and measures the spacing of the latch pulses.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ADDR  = 2'd1,
    XS_STRB  = 2'd2,
    XS_RECOV = 2'd3
  } xs_state_e;

  // extra strobe cycles beyond the base cycle for a 2-bit wait code
  function automatic logic [1:0] strobe_extra(input logic [1:0] code);
    logic [1:0] r;
    case (code)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd1;
      default: r = 2'd2;
    endcase
    return r;
  endfunction

  // top wait code inserts an idle cycle before the next address
  function automatic logic adds_recovery(input logic [1:0] code);
    return code == 2'd3;
  endfunction

  // lower sector only exists for limit codes 2..7; seg is addr[15:13]
  function automatic logic split_lower(input logic [2:0] lim, input logic [2:0] seg);
    return (lim >= 3'd2) && (seg < lim);
  endfunction

endpackage

// File: rtl/xbus_regs.sv
module xbus_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              en,
  output logic [2:0]        lim,
  output logic [1:0]        ws_lo,
  output logic [1:0]        ws_hi,
  output logic              keep,
  output logic [2:0]        hmask
);
  localparam int USED1 = 4;

  logic [DATA_W-1:0] reg0;
  logic [USED1-1:0]  reg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg0 <= '0;
      reg1 <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) reg1 <= cfg_wdata[USED1-1:0];
      else         reg0 <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) cfg_rdata[USED1-1:0] = reg1;
    else         cfg_rdata = reg0;
  end

  assign en    = reg0[0];
  assign lim   = reg0[3:1];
  assign ws_lo = reg0[5:4];
  assign ws_hi = reg0[7:6];
  assign keep  = reg1[0];
  assign hmask = reg1[3:1];
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HI_W   = 8
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        lim,
  input  logic [1:0]        ws_lo,
  input  logic [1:0]        ws_hi,
  input  logic [2:0]        hmask,
  output logic [1:0]        sel_code,
  output logic              in_lower,
  output logic [HI_W-1:0]   hi_oe
);
  localparam int CNT_W = $clog2(HI_W + 1);

  logic [2:0]       seg;
  logic [CNT_W-1:0] hi_count;

  assign seg      = acc_addr[ADDR_W-1 -: 3];
  assign in_lower = split_lower(lim, seg);
  assign sel_code = in_lower ? ws_lo : ws_hi;

  // number of high address pins kept by the interface
  assign hi_count = (hmask == 3'b111) ? '0 : (CNT_W'(HI_W) - CNT_W'(hmask));

  for (genvar i = 0; i < HI_W; i++) begin : g_hi_oe
    assign hi_oe[i] = (hi_count > CNT_W'(i));
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [1:0]        sel_code,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_drv,
  output logic              ad_oe,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_start,
  output logic              strobe_last
);
  xs_state_e         state;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wd;
  logic [1:0]        cnt;
  logic              recov_pend;

  assign acc_start   = (state == XS_IDLE) && en && req;
  assign strobe_last = (state == XS_STRB) && (cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= XS_IDLE;
      lat_addr   <= '0;
      lat_we     <= 1'b0;
      lat_wd     <= '0;
      cnt        <= '0;
      recov_pend <= 1'b0;
      ready      <= 1'b0;
      rdata      <= '0;
    end else begin
      ready <= 1'b0;
      case (state)
        XS_IDLE: begin
          if (acc_start) begin
            lat_addr <= addr;
            lat_we   <= we;
            lat_wd   <= wdata;
            state    <= XS_ADDR;
          end
        end
        XS_ADDR: begin
          cnt        <= strobe_extra(sel_code);
          recov_pend <= adds_recovery(sel_code);
          state      <= XS_STRB;
        end
        XS_STRB: begin
          if (cnt == 2'd0) begin
            if (!lat_we) rdata <= ad_in;
            ready <= 1'b1;
            state <= recov_pend ? XS_RECOV : XS_IDLE;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign ale    = (state == XS_ADDR);
  assign rd_n   = !((state == XS_STRB) && !lat_we);
  assign wr_n   = !((state == XS_STRB) && lat_we);
  assign ad_oe  = (state == XS_ADDR) || ((state == XS_STRB) && lat_we);
  assign ad_drv = (state == XS_ADDR) ? lat_addr[DATA_W-1:0] : lat_wd;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              bus_own,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_keep,
  output logic [ADDR_W-DATA_W-1:0] a_o,
  output logic [ADDR_W-DATA_W-1:0] a_oe
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              en, keep;
  logic [2:0]        lim, hmask;
  logic [1:0]        ws_lo, ws_hi, sel_code;
  logic              in_lower;
  logic [HI_W-1:0]   hi_oe;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] ad_drv, last_ad;
  logic              acc_start, strobe_last;

  xbus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en(en), .lim(lim),
    .ws_lo(ws_lo), .ws_hi(ws_hi), .keep(keep), .hmask(hmask)
  );

  xbus_decode #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_dec (
    .acc_addr(lat_addr), .lim(lim), .ws_lo(ws_lo), .ws_hi(ws_hi),
    .hmask(hmask), .sel_code(sel_code), .in_lower(in_lower), .hi_oe(hi_oe)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ad_in(ad_in), .sel_code(sel_code), .lat_addr(lat_addr),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_drv(ad_drv), .ad_oe(ad_oe),
    .ready(ready), .rdata(rdata), .acc_start(acc_start),
    .strobe_last(strobe_last)
  );

  // last value driven on the shared lines, shown while they float
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_ad <= '0;
    else if (ad_oe) last_ad <= ad_drv;
  end

  assign ad_o    = ad_oe ? ad_drv : last_ad;
  assign ad_keep = keep && !ad_oe;
  assign bus_own = en;
  assign a_oe    = {HI_W{en}} & hi_oe;
  assign a_o     = lat_addr[ADDR_W-1 -: HI_W] & a_oe;
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_o,
  input logic              ready,
  input logic              bus_own,
  input logic [HI_W-1:0]   a_o,
  input logic [HI_W-1:0]   a_oe,
  input logic              strobe_last
);
  logic [2:0] scnt;
  logic       strb;

  assign strb = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               scnt <= '0;
    else if (!strb)           scnt <= '0;
    else if (scnt != 3'd7)    scnt <= scnt + 3'd1;
  end

  a_r4_ale_to_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> strb);
  a_r9_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r10_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r10_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(strobe_last));
  a_r5_strobe_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> (scnt < 3'd3));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r12_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> $stable(ad_o));
  a_r11_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a_o & ~a_oe) == '0);
  a_r3_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(bus_own));
endmodule

bind xbus_ctrl xbus_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .ad_o(ad_o), .ready(ready), .bus_own(bus_own),
  .a_o(a_o), .a_oe(a_oe), .strobe_last(strobe_last)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic req = 0, we = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, rdata, ad_o, ad_in = 0, a_o, a_oe;
  logic ready, bus_own, ale, rd_n, wr_n, ad_oe, ad_keep;

  int n_checks = 0, n_fail = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
    .bus_own(bus_own), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_o(ad_o),
    .ad_oe(ad_oe), .ad_in(ad_in), .ad_keep(ad_keep), .a_o(a_o), .a_oe(a_oe)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 3;
  endfunction

  function automatic int exp_period(input int code);
    return (code == 3) ? 6 : 2 + exp_len(code);
  endfunction

  function automatic logic [7:0] exp_mask(input int m);
    int n;
    n = (m == 7) ? 0 : 8 - m;
    return 8'((1 << n) - 1);
  endfunction

  function automatic logic [7:0] cfg0(input int en, input int lim, input int lo, input int hi);
    return 8'(en | (lim << 1) | (lo << 4) | (hi << 6));
  endfunction

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input bit sel, output logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  // one access; ad_in set to 0x40+index in each strobe cycle
  task automatic do_access(input logic [15:0] a, input bit w, input logic [7:0] wd,
                           output int slen, output int ale_n, output logic [7:0] ad_ale,
                           output logic [7:0] hi_ale, output logic [7:0] hioe_ale,
                           output bit strb_ok, output logic [7:0] rv, output int rdy_n);
    bit fin;
    @(negedge clk);
    addr = a; we = w; wdata = wd; req = 1;
    slen = 0; ale_n = 0; rdy_n = 0; strb_ok = 1; fin = 0;
    ad_ale = 0; hi_ale = 0; hioe_ale = 0; rv = 0;
    for (int i = 0; i < 20 && !fin; i++) begin
      @(negedge clk);
      if (ale) begin
        ale_n++; ad_ale = ad_o; hi_ale = a_o; hioe_ale = a_oe; req = 0;
        if (ad_oe !== 1'b1) strb_ok = 0;
      end
      if (!rd_n || !wr_n) begin
        if (w && (wr_n !== 1'b0 || rd_n !== 1'b1 || ad_oe !== 1'b1 || ad_o !== wd)) strb_ok = 0;
        if (!w && (rd_n !== 1'b0 || wr_n !== 1'b1 || ad_oe !== 1'b0)) strb_ok = 0;
        ad_in = 8'(8'h40 + slen);
        slen++;
      end
      if (ready) begin rdy_n++; rv = rdata; fin = 1; end
    end
    req = 0;
    @(negedge clk);
    if (ready) rdy_n++;
  endtask

  task automatic t_reset();
    logic [7:0] d0, d1;
    cfg_read(0, d0); cfg_read(1, d1);
    check(d0 == 0 && d1 == 0, "R1 cfg reset", {d1, d0}, 0);
    check(ale == 0 && rd_n == 1 && wr_n == 1 && ad_oe == 0 && ready == 0,
          "R1 strobes idle", {ale, rd_n, wr_n, ad_oe, ready}, 5'b01100);
    check(bus_own == 0 && a_oe == 0, "R1 ownership", {bus_own, a_oe}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    cfg_write(1, 8'hFF); cfg_read(1, d);
    check(d == 8'h0F, "R2 reserved bits read 0", d, 8'h0F);
    cfg_write(0, 8'hA4); cfg_read(0, d);
    check(d == 8'hA4, "R2 reg0 readback", d, 8'hA4);
    cfg_write(1, 8'h00); cfg_write(0, 8'h00);
  endtask

  task automatic t_disabled();
    int seen_ale = 0, seen_rdy = 0;
    cfg_write(0, cfg0(0, 0, 0, 0));
    @(negedge clk); addr = 16'h3456; we = 0; req = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ale) seen_ale++;
      if (ready) seen_rdy++;
      check(bus_own == 0 && a_oe == 0, "R3 pins released", {bus_own, a_oe}, 0);
    end
    req = 0;
    check(seen_ale == 0 && seen_rdy == 0, "R3 request ignored", seen_ale + seen_rdy, 0);
  endtask

  task automatic t_waits();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 2; l++) begin
        cfg_write(0, cfg0(1, l, 3 - c, c));
        check(bus_own == 1, "R3 owned when enabled", bus_own, 1);
        do_access(16'h5A3C + 16'(c), 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
        check(sl == exp_len(c), "R5 R8 strobe length by upper code", sl, exp_len(c));
        check(an == 1 && aa == 8'(8'h3C + c), "R4 one ale with low address", {an[7:0], aa}, {8'd1, 8'(8'h3C + c)});
      end
    end
  endtask

  task automatic t_sector();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    for (int k = 2; k < 8; k++) begin
      cfg_write(0, cfg0(1, k, 0, 2));
      do_access(16'((k << 13) - 1), 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
      check(sl == 1, "R7 below start uses lower code", sl, 1);
      do_access(16'(k << 13), 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
      check(sl == 3, "R7 at start uses upper code", sl, 3);
    end
    cfg_write(0, cfg0(1, 2, 0, 2));
    do_access(16'h2200, 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
    check(sl == 1, "R7 base in lower sector", sl, 1);
    cfg_write(0, cfg0(1, 1, 0, 2));
    do_access(16'h2200, 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
    check(sl == 3, "R8 limit 1 single sector", sl, 3);
  endtask

  task automatic t_write();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    for (int c = 0; c < 4; c++) begin
      cfg_write(0, cfg0(1, 0, 0, c));
      do_access(16'h7712, 1, 8'(8'hC5 ^ c), sl, an, aa, ha, ho, ok, rv, rn);
      check(ok, "R9 write drives data under wr_n", ok, 1);
      check(sl == exp_len(c) && rn == 1, "R9 write length and ready", {sl[7:0], rn[7:0]}, {8'(exp_len(c)), 8'd1});
    end
  endtask

  task automatic t_read();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    for (int c = 0; c < 4; c++) begin
      cfg_write(0, cfg0(1, 0, 0, c));
      do_access(16'h9081, 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
      check(ok, "R10 read floats bus under rd_n", ok, 1);
      check(rv == 8'(8'h40 + exp_len(c) - 1), "R10 sample in last strobe cycle", rv, 8'(8'h40 + exp_len(c) - 1));
      check(rn == 1, "R10 ready one cycle", rn, 1);
    end
  endtask

  task automatic t_recov();
    int first, second, idx;
    for (int c = 0; c < 4; c++) begin
      cfg_write(0, cfg0(1, 0, 0, c));
      @(negedge clk); addr = 16'h4444; we = 0; req = 1;
      first = -1; second = -1; idx = 0;
      for (int i = 0; i < 30 && second < 0; i++) begin
        @(negedge clk); idx++;
        if (ale) begin if (first < 0) first = idx; else second = idx; end
      end
      req = 0;
      repeat (8) @(negedge clk);
      check(second - first == exp_period(c), "R6 ale spacing", second - first, exp_period(c));
    end
  endtask

  task automatic t_mask();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    for (int m = 0; m < 8; m++) begin
      cfg_write(1, 8'(m << 1));
      cfg_write(0, cfg0(1, 0, 0, 0));
      do_access(16'hF5A3, 0, 0, sl, an, aa, ha, ho, ok, rv, rn);
      check(ho == exp_mask(m), "R11 high pin ownership", ho, exp_mask(m));
      check(ha == (8'hF5 & exp_mask(m)), "R11 masked address", ha, 8'hF5 & exp_mask(m));
    end
    cfg_write(1, 8'h00);
  endtask

  task automatic t_keeper();
    int sl, an, rn; logic [7:0] aa, ha, ho, rv; bit ok;
    cfg_write(1, 8'h01);
    cfg_write(0, cfg0(1, 0, 0, 1));
    do_access(16'h3000, 1, 8'h3C, sl, an, aa, ha, ho, ok, rv, rn);
    @(negedge clk);
    check(ad_oe == 0 && ad_o == 8'h3C, "R12 holds last driven value", ad_o, 8'h3C);
    check(ad_keep == 1, "R12 keeper active enabled", ad_keep, 1);
    cfg_write(0, cfg0(0, 0, 0, 0));
    check(ad_keep == 1 && ad_o == 8'h3C, "R12 keeper active disabled", {ad_keep, ad_o}, {1'b1, 8'h3C});
    cfg_write(1, 8'h00);
    check(ad_keep == 0, "R12 keeper off", ad_keep, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_disabled();
    t_waits();
    t_sector();
    t_write();
    t_read();
    t_recov();
    t_mask();
    t_keeper();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule